// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock for an I2C master. It uses a 7-bit down counter. A write to the transmit buffer arms the counter with a reload value taken from a configuration register. The counter then counts down once for each count-enable strobe. Each time it reaches zero it rolls over: SCL toggles and the counter reloads itself. One half-period of SCL is therefore one full countdown, and one SCL period is two rollovers.

The host pulses the count-enable strobe twice per instruction cycle. If the strobe slows down or stops, for example while the chip sleeps, SCL slows down or freezes with it. After nine SCL periods (eight data bits and the acknowledge), the generator stops. It holds SCL high, pulses `done` for one clock and waits for the next buffer write. A reload value of zero cannot be used: the start is refused and flagged. Auto-reload only happens while master mode is enabled.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: After synchronous reset, `scl` is 1 and `busy`, `done` and `cfg_err` are 0.
- R2: A `buf_wr` pulse takes effect only when `master_en` is 1, the block is idle and `reload_reg[6:0]` is nonzero. It then starts the block: `busy` is 1 and `scl` is 1 from the next clock. Bit 7 of `reload_reg` has no effect.
- R3: With reload value N, SCL toggles at every (N+1)th `tick_en` strobe after the start. Clocks with no strobe leave `scl` and the count unchanged.
- R4: After 18 rollovers (9 full SCL periods), `busy` falls and `scl` stays at 1. In the same clock edge `done` rises, and it stays high for exactly one clock.
- R5: A `buf_wr` with master mode on, the block idle and `reload_reg[6:0]` equal to 0 does not start the block. Instead `cfg_err` is 1 for exactly one clock.
- R6: While `busy` is 1, neither `buf_wr` nor changes of `reload_reg` have any effect. The reload value is captured at the start.
- R7: While `master_en` is 0, `buf_wr` is ignored. If `master_en` falls during an operation, the next rollover still toggles `scl` and then stops the block without a `done` pulse. `scl` then holds that level.
- R8: After a stop, a new valid `buf_wr` re-arms the counter from the current reload value and releases `scl` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable strobe, one counter step per high clock |
| master_en | input | 1 | Master mode enable; permits start and auto-reload |
| reload_reg | input | 8 | Configuration register; low 7 bits are the reload value |
| buf_wr | input | 1 | Transmit-buffer write pulse, starts an operation |
| scl | output | 1 | Generated serial clock level |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse when an operation completes |
| cfg_err | output | 1 | One-clock pulse when a start with reload zero is refused |

## Verification
The assertions check on every cycle the following properties:
- SCL never moves without a strobe or a start.
- The counter never exceeds the captured reload value.
- `done` lasts one clock, coincides with the end of `busy` and finds SCL high.
- A refused start leaves the block idle.
- Nothing starts while master mode is off.

The exact half-period length for each reload value can only be shown by the bench's sweeps, as can the rollover count at which the operation ends. The bench sweeps every reload value from 1 to 12, at two strobe spacings and with bit 7 set. The same holds for immunity to mid-operation writes, for the master-mode abort that holds SCL low, and for the re-arm after a stop.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;

    typedef enum logic {
        BRG_IDLE = 1'b0,
        BRG_RUN  = 1'b1
    } brg_state_e;

    typedef struct packed {
        logic start;
        logic refuse;
        logic roll;
        logic finish;
        logic abort;
        logic reload;
    } brg_ctl_t;

    function automatic logic reload_legal(input logic [6:0] v);
        return v != '0;
    endfunction

    function automatic int halves_per_xfer(input int bits);
        return 2 * bits;
    endfunction

endpackage

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         at_zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/brg_half_tracker.sv
module brg_half_tracker #(
    parameter int HALVES = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic roll,
    output logic scl,
    output logic last_half
);
    localparam int HW = (HALVES > 1) ? $clog2(HALVES) : 1;

    logic [HW-1:0] half_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_idx <= '0;
            scl      <= 1'b1;
        end else if (start) begin
            half_idx <= '0;
            scl      <= 1'b1;
        end else if (roll) begin
            half_idx <= half_idx + 1'b1;
            scl      <= ~scl;
        end
    end

    assign last_half = (half_idx == HW'(HALVES - 1));
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen
    import i2c_brg_pkg::*;
#(
    parameter int RELOAD_W      = 7,
    parameter int BITS_PER_XFER = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic                master_en,
    input  logic [RELOAD_W:0]   reload_reg,
    input  logic                buf_wr,
    output logic                scl,
    output logic                busy,
    output logic                done,
    output logic                cfg_err
);
    localparam int HALVES = halves_per_xfer(BITS_PER_XFER);

    brg_state_e          state_q;
    brg_ctl_t            ctl;
    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] cnt_q;
    logic [RELOAD_W-1:0] load_val;
    logic                at_zero;
    logic                last_half;
    logic                req_ok;

    assign req_ok = buf_wr && master_en && (state_q == BRG_IDLE);

    always_comb begin
        ctl        = '0;
        ctl.start  = req_ok && reload_legal(reload_reg[RELOAD_W-1:0]);
        ctl.refuse = req_ok && !reload_legal(reload_reg[RELOAD_W-1:0]);
        ctl.roll   = (state_q == BRG_RUN) && tick_en && at_zero;
        ctl.finish = ctl.roll && last_half;
        ctl.abort  = ctl.roll && !last_half && !master_en;
        ctl.reload = ctl.roll && !last_half && master_en;
    end

    assign load_val = ctl.start ? reload_reg[RELOAD_W-1:0] : reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BRG_IDLE;
            reload_q <= '0;
            done     <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            done    <= ctl.finish;
            cfg_err <= ctl.refuse;
            if (ctl.start) begin
                state_q  <= BRG_RUN;
                reload_q <= reload_reg[RELOAD_W-1:0];
            end else if (ctl.finish || ctl.abort) begin
                state_q <= BRG_IDLE;
            end
        end
    end

    brg_down_counter #(.W(RELOAD_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.start || ctl.reload),
        .load_val (load_val),
        .step     (tick_en && (state_q == BRG_RUN)),
        .cnt      (cnt_q),
        .at_zero  (at_zero)
    );

    brg_half_tracker #(.HALVES(HALVES)) u_half (
        .clk       (clk),
        .rst       (rst),
        .start     (ctl.start),
        .roll      (ctl.roll),
        .scl       (scl),
        .last_half (last_half)
    );

    assign busy = (state_q == BRG_RUN);
endmodule

// File: rtl/i2c_scl_rate_gen_chk.sv
module i2c_scl_rate_gen_chk #(
    parameter int RW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_en,
    input logic          master_en,
    input logic          buf_wr,
    input logic          scl,
    input logic          busy,
    input logic          done,
    input logic          cfg_err,
    input logic [RW-1:0] cnt,
    input logic [RW-1:0] rl
);
    assert_scl_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !buf_wr) |=> $stable(scl));

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= rl));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && scl && $past(busy)));

    assert_refuse_idle_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

    assert_no_start_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!master_en && !busy) |=> !busy);
endmodule

bind i2c_scl_rate_gen i2c_scl_rate_gen_chk #(.RW(RELOAD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .master_en (master_en),
    .buf_wr    (buf_wr),
    .scl       (scl),
    .busy      (busy),
    .done      (done),
    .cfg_err   (cfg_err),
    .cnt       (cnt_q),
    .rl        (reload_q)
);

// File: tb/i2c_scl_rate_gen_tb.sv
module i2c_scl_rate_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       master_en = 1'b0;
    logic [7:0] reload_reg = 8'h00;
    logic       buf_wr = 1'b0;
    logic       scl, busy, done, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_scl_rate_gen u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .master_en(master_en),
        .reload_reg(reload_reg), .buf_wr(buf_wr),
        .scl(scl), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_op(input logic [7:0] val);
        reload_reg = val;
        buf_wr = 1'b1;
        step();
        buf_wr = 1'b0;
    endtask

    // full operation, reload r, gap idle clocks between strobes,
    // optional disturbing write at tick 3 (R6)
    task automatic run_op(input int r, input int gap, input bit disturb);
        int total;
        total = 18 * (r + 1);
        start_op(8'h80 | 8'(r));
        chk("R2", "busy after start", busy, 1);
        chk("R2", "scl after start", scl, 1);
        for (int n = 1; n <= total; n++) begin
            tick_en = 1'b1;
            if (disturb && n == 3) begin
                buf_wr = 1'b1;
                reload_reg = 8'h01;
            end
            step();
            tick_en = 1'b0;
            buf_wr = 1'b0;
            chk("R3", "scl level", scl, ((n / (r + 1)) % 2 == 0) ? 1 : 0);
            chk("R4", "busy", busy, (n < total) ? 1 : 0);
            chk("R4", "done", done, (n == total) ? 1 : 0);
            for (int g = 0; g < gap; g++) begin
                step();
                chk("R3", "scl held without strobe", scl, ((n / (r + 1)) % 2 == 0) ? 1 : 0);
                if (n == total) chk("R4", "done one clock", done, 0);
            end
        end
        if (gap == 0) begin
            step();
            chk("R4", "done one clock", done, 0);
        end
        for (int k = 0; k < 5; k++) begin
            tick_en = 1'b1;
            step();
            chk("R4", "scl held high after stop", scl, 1);
            chk("R4", "stays idle", busy, 0);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        chk("R1", "reset scl", scl, 1);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset cfg_err", cfg_err, 0);

        // R7: master mode off, write ignored
        start_op(8'h05);
        chk("R7", "no start with master off", busy, 0);
        master_en = 1'b1;

        // R5: zero reload refused, bit 7 set does not rescue it
        start_op(8'h80);
        chk("R5", "cfg_err pulse", cfg_err, 1);
        chk("R5", "not started", busy, 0);
        step();
        chk("R5", "cfg_err one clock", cfg_err, 0);

        // R3/R4: sweep of reload values, two strobe spacings
        for (int r = 1; r <= 12; r++) begin
            run_op(r, 0, 1'b0);
            run_op(r, 1, 1'b0);
        end

        // R6: write and reload change mid-operation ignored
        run_op(5, 0, 1'b1);

        // R7: master mode falls in first half -> stop low, no done
        start_op(8'h03);
        for (int n = 1; n <= 4; n++) begin
            if (n == 2) master_en = 1'b0;
            tick_en = 1'b1;
            step();
            tick_en = 1'b0;
            chk("R7", "done absent", done, 0);
        end
        chk("R7", "scl toggled low then held", scl, 0);
        chk("R7", "stopped", busy, 0);
        for (int k = 0; k < 10; k++) begin
            tick_en = 1'b1;
            step();
            chk("R7", "scl held low", scl, 0);
            chk("R7", "no done after abort", done, 0);
        end
        tick_en = 1'b0;

        // R8: re-arm releases scl, uses new reload value
        master_en = 1'b1;
        start_op(8'h02);
        chk("R8", "scl released", scl, 1);
        chk("R8", "busy", busy, 1);
        for (int n = 1; n <= 3; n++) begin
            tick_en = 1'b1;
            step();
            tick_en = 1'b0;
            chk("R8", "half period of 3", scl, (n < 3) ? 1 : 0);
        end
        // R3: no strobes at all, state frozen
        for (int k = 0; k < 40; k++) begin
            step();
            chk("R3", "frozen without strobe", scl, 0);
        end
        chk("R3", "still busy when frozen", busy, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule